// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Address Front End

This block is the serial front end of a two-wire EEPROM slave. It brings the SCL and SDA lines into the system clock domain and detects start and stop conditions. After a start it shifts in the first byte, and it then decides whether to acknowledge that byte by pulling SDA low during the ninth clock.

Two control codes in the upper nibble are recognised. One selects normal memory access. The other selects a command that programs the protect register. The three chip-select bits must equal the strapped pins, and the last bit chooses read or write. No acknowledge is given while the memory controller reports a write cycle in progress. No acknowledge is given to a protect command once the protect register is already programmed.

On an acknowledged address the block emits a one-cycle match pulse and holds the decoded operation until the next start or stop. The memory controller reads it from there. On any mismatch the block falls back to standby and waits for a fresh start.

Top module: `eaf_top`

## Requirements
- R1: After reset `sda_pull_o`, `match_o` and `prot_cmd_o` are 0 and `op_o` is 0 (none).
- R2: A start condition (SDA falling while SCL is high) begins capture of an address byte. The byte is sampled on SCL rising edges, most significant bit first.
- R3: Upper nibble 1010 with bits [3:1] equal to `chip_sel_i` is acknowledged. `op_o` becomes 1 (read) when bit 0 is 1 and 2 (write) when bit 0 is 0.
- R4: Upper nibble 0110 with matching chip select, bit 0 equal to 0, and `prot_set_i` low is acknowledged with `op_o` = 3 (protect) and `prot_cmd_o` = 1.
- R5: Upper nibble 0110 is not acknowledged when `prot_set_i` is high or when bit 0 is 1.
- R6: Any other nibble, or a chip-select mismatch, gets no acknowledge and no match pulse, and leaves `op_o` at 0. Later bytes are ignored until a new start.
- R7: While `busy_i` is high, starts are ignored and no address is acknowledged.
- R8: On an acknowledge, `sda_pull_o` is high from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth. `match_o` pulses for exactly one cycle, once per acknowledged address.
- R9: A stop condition (SDA rising while SCL is high) aborts any byte in progress and returns `op_o` and `prot_cmd_o` to 0.
- R10: A start in the middle of a byte discards the partial byte and restarts capture.
- R11: After an acknowledge, `op_o` and `prot_cmd_o` hold their decoded values until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| chip_sel_i | input | 3 | Strapped chip-select pins |
| prot_set_i | input | 1 | Protect register already programmed |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| match_o | output | 1 | One-cycle pulse on an acknowledged address |
| op_o | output | 2 | Decoded operation: 0 none, 1 read, 2 write, 3 protect |
| prot_cmd_o | output | 1 | Current operation is a protect-register command |

## Verification
The bench checks that a protect command with the read bit set is refused. A design that decoded only the nibble would acknowledge it as a protect write. A mismatched address is followed by a second byte without a start, and that byte must stay unacknowledged. A block that did not return to standby would capture it as a new address. A start three bits into a byte, and a stop in the middle of a byte, check that stale shift state is discarded. Holding `busy_i` high shows whether the acknowledge is suppressed, and random mixes of codes, strap values, protect state and busy cover the combinations.

// File: rtl/eaf_pkg.sv
package eaf_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_PROT  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DECIDE,
    ST_ACK,
    ST_HOLD
  } st_e;

  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_MEM  = 4'b1010;
  localparam logic [CODE_W-1:0] CODE_PROT = 4'b0110;
endpackage

// File: rtl/eaf_sync.sv
module eaf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign q_o    = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/eaf_cond.sv
module eaf_cond (
  input  logic scl_q_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  // SDA may only move while SCL is low during data; a move with SCL high is a frame marker
  assign start_o = scl_q_i & sda_fall_i;
  assign stop_o  = scl_q_i & sda_rise_i;
endmodule

// File: rtl/eaf_decode.sv
module eaf_decode
  import eaf_pkg::*;
#(
  parameter int unsigned CS_W = 3
) (
  input  logic [CODE_W+CS_W:0] byte_i,
  input  logic [CS_W-1:0]      cs_i,
  input  logic                 prot_set_i,
  input  logic                 busy_i,
  output op_e                  op_o
);
  localparam int unsigned B_W = CODE_W + CS_W + 1;

  logic [CODE_W-1:0] code;
  logic [CS_W-1:0]   cs_field;
  logic              rd_bit;
  logic              cs_hit;

  assign code     = byte_i[B_W-1 -: CODE_W];
  assign cs_field = byte_i[CS_W:1];
  assign rd_bit   = byte_i[0];
  assign cs_hit   = (cs_field == cs_i);

  always_comb begin
    op_o = OP_NONE;
    if (!busy_i && cs_hit) begin
      if (code == CODE_MEM) begin
        op_o = rd_bit ? OP_READ : OP_WRITE;
      end else if (code == CODE_PROT && !rd_bit && !prot_set_i) begin
        op_o = OP_PROT;
      end
    end
  end
endmodule

// File: rtl/eaf_top.sv
module eaf_top
  import eaf_pkg::*;
#(
  parameter int unsigned CS_W        = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [CS_W-1:0] chip_sel_i,
  input  logic            prot_set_i,
  input  logic            busy_i,
  output logic            sda_pull_o,
  output logic            match_o,
  output logic [1:0]      op_o,
  output logic            prot_cmd_o
);
  localparam int unsigned B_W   = CODE_W + CS_W + 1;
  localparam int unsigned CNT_W = $clog2(B_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(B_W - 1);

  logic scl_q, scl_rise, scl_fall;
  logic sda_q, sda_rise, sda_fall;
  logic start_evt, stop_evt;

  eaf_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .d_i(scl_i), .q_o(scl_q), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  eaf_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .d_i(sda_i), .q_o(sda_q), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  eaf_cond u_cond (
    .scl_q_i(scl_q), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  st_e              st_q;
  logic [B_W-1:0]   shift_q;
  logic [CNT_W-1:0] cnt_q;
  op_e              op_q, dec_op;
  logic             pull_q, match_q, prot_q;

  eaf_decode #(.CS_W(CS_W)) u_decode (
    .byte_i(shift_q), .cs_i(chip_sel_i), .prot_set_i(prot_set_i),
    .busy_i(busy_i), .op_o(dec_op)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      shift_q <= '0;
      cnt_q   <= '0;
      op_q    <= OP_NONE;
      pull_q  <= 1'b0;
      match_q <= 1'b0;
      prot_q  <= 1'b0;
    end else begin
      match_q <= 1'b0;
      if (stop_evt) begin
        st_q   <= ST_IDLE;
        op_q   <= OP_NONE;
        prot_q <= 1'b0;
        pull_q <= 1'b0;
      end else if (start_evt) begin
        st_q   <= busy_i ? ST_IDLE : ST_ADDR;
        cnt_q  <= '0;
        op_q   <= OP_NONE;
        prot_q <= 1'b0;
        pull_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              shift_q <= {shift_q[B_W-2:0], sda_q};
              cnt_q   <= cnt_q + 1'b1;
              if (cnt_q == LAST_BIT) st_q <= ST_DECIDE;
            end
          end
          ST_DECIDE: begin
            // decide at the falling edge so busy/protect state is current
            if (scl_fall) begin
              if (dec_op != OP_NONE) begin
                pull_q  <= 1'b1;
                match_q <= 1'b1;
                op_q    <= dec_op;
                prot_q  <= (dec_op == OP_PROT);
                st_q    <= ST_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              pull_q <= 1'b0;
              st_q   <= ST_HOLD;
            end
          end
          ST_HOLD: ;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign match_o    = match_q;
  assign op_o       = op_q;
  assign prot_cmd_o = prot_q;
endmodule

// File: rtl/eaf_checker.sv
module eaf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       prot_set_i,
  input logic       stop_evt,
  input logic       sda_pull_o,
  input logic       match_o,
  input logic [1:0] op_o,
  input logic       prot_cmd_o
);
  assert_match_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  assert_match_pulls_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> sda_pull_o);

  assert_pull_has_op_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> (op_o != 2'd0));

  assert_busy_no_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> !$past(busy_i));

  assert_prot_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && op_o == 2'd3) |-> !$past(prot_set_i));

  assert_prot_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && op_o == 2'd3) |-> prot_cmd_o);

  assert_stop_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> (op_o == 2'd0 && !sda_pull_o && !prot_cmd_o));
endmodule

bind eaf_top eaf_checker u_eaf_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .prot_set_i(prot_set_i),
  .stop_evt(stop_evt), .sda_pull_o(sda_pull_o), .match_o(match_o),
  .op_o(op_o), .prot_cmd_o(prot_cmd_o)
);

// File: tb/tb_eaf_top.sv
module tb_eaf_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] chip_sel = 3'b000;
  logic prot_set = 1'b0, busy = 1'b0;
  logic sda_pull, match, prot_cmd;
  logic [1:0] op;
  logic sda_line;

  int checks = 0, errors = 0, match_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  eaf_top dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .chip_sel_i(chip_sel), .prot_set_i(prot_set), .busy_i(busy),
    .sda_pull_o(sda_pull), .match_o(match), .op_o(op), .prot_cmd_o(prot_cmd)
  );

  always @(posedge clk) if (match) match_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    end
  endtask

  task automatic ack_bit(output bit acked);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    acked = (sda_line == 1'b0);
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  function automatic int exp_op(input logic [7:0] b, input logic [2:0] cs,
                                input bit prot, input bit bsy);
    if (bsy || b[3:1] != cs) return 0;
    if (b[7:4] == 4'b1010) return b[0] ? 1 : 2;
    if (b[7:4] == 4'b0110 && !b[0] && !prot) return 3;
    return 0;
  endfunction

  task automatic run_addr(input logic [7:0] b, input logic [2:0] cs,
                          input bit prot, input bit bsy, input string req);
    bit acked;
    int m0, e;
    chip_sel = cs; prot_set = prot; busy = bsy;
    e = exp_op(b, cs, prot, bsy);
    bus_start();
    m0 = match_cnt;
    send_bits(b, 8);
    ack_bit(acked);
    w(3);
    check(acked == (e != 0), {req, " ack"}, acked, e != 0);
    check((match_cnt - m0) == (e != 0 ? 1 : 0), "R8 match pulses", match_cnt - m0, e != 0);
    check(int'(op) == e, {req, " R11 op held"}, op, e);
    check(prot_cmd == (e == 3), {req, " R11 prot flag"}, prot_cmd, e == 3);
    check(sda_pull == 1'b0, "R8 release after ninth", sda_pull, 0);
    bus_stop();
    w(4);
    check(op == 2'd0 && !prot_cmd, "R9 stop clears op", op, 0);
    busy = 1'b0; prot_set = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    bit acked;
    int m0;
    void'($urandom(32'd4711));
    w(3);
    check(!sda_pull && !match && op == 2'd0 && !prot_cmd, "R1 reset state", op, 0);
    rst_n = 1'b1;
    w(4);
    check(!sda_pull && !match && op == 2'd0, "R1 after release", op, 0);

    run_addr(8'b1010_0111, 3'b011, 0, 0, "R2 R3 read");
    run_addr(8'b1010_1010, 3'b101, 1, 0, "R3 write");
    run_addr(8'b0110_0100, 3'b010, 0, 0, "R4 protect");
    run_addr(8'b0110_0100, 3'b010, 1, 0, "R5 protect locked");
    run_addr(8'b0110_0101, 3'b010, 0, 0, "R5 protect read bit");
    run_addr(8'b1011_0000, 3'b000, 0, 0, "R6 bad code");
    run_addr(8'b1010_1100, 3'b111, 0, 0, "R6 cs mismatch");
    run_addr(8'b1010_0000, 3'b000, 0, 1, "R7 busy");

    // R6: after a mismatch, a byte without start must be ignored
    chip_sel = 3'b001;
    bus_start(); send_bits(8'b1010_0000, 8); ack_bit(acked);
    m0 = match_cnt;
    send_bits(8'b1010_0010, 8); ack_bit(acked);
    check(!acked, "R6 standby ignores byte", acked, 0);
    check(match_cnt == m0 && op == 2'd0, "R6 no match in standby", match_cnt - m0, 0);
    bus_stop(); w(4);

    // R10: start three bits into a byte restarts capture
    chip_sel = 3'b110;
    bus_start(); send_bits(8'b0101_0000, 3);
    m0 = match_cnt;
    bus_start(); send_bits(8'b1010_1101, 8); ack_bit(acked);
    w(3);
    check(acked, "R10 restart acked", acked, 1);
    check(op == 2'd1 && match_cnt == m0 + 1, "R10 restart op", op, 1);
    bus_stop(); w(4);

    // R9: stop mid-byte then clocked bits get no ack
    bus_start(); send_bits(8'b1010_1101, 4); bus_stop(); w(2);
    scl_m = 1'b0; w(Q);
    m0 = match_cnt;
    send_bits(8'b1101_0000, 4); ack_bit(acked);
    check(!acked && match_cnt == m0 && op == 2'd0, "R9 abort mid-byte", acked, 0);
    scl_m = 1'b1; w(Q);

    for (int k = 0; k < 60; k++) begin
      logic [7:0] b;
      logic [2:0] cs;
      int sel;
      cs  = 3'($urandom);
      sel = $urandom % 4;
      b[7:4] = (sel == 1) ? 4'b0110 : (sel == 2) ? 4'($urandom) : 4'b1010;
      b[3:1] = ($urandom % 4 != 0) ? cs : 3'($urandom);
      b[0]   = 1'($urandom);
      run_addr(b, cs, 1'($urandom), ($urandom % 5) == 0, "R3 R4 R5 R6 R7 random");
    end

    summary();
  end
endmodule